// File: doc/BRIEF.md
# QoS Shared-Port Arbiter

This block decides which of several masters may use one shared slave port, such as a memory controller port. Each master raises a request and gives a transfer size in bytes. The arbiter answers with a one-hot grant. The winner is chosen from four inputs: a static priority per master, a token bucket per master that limits bandwidth, an opportunistic flag for best-effort masters, and a wait-age counter that lifts any request that has waited too long above every other rule.

The grant behaves as the valid side of a handshake, and `gnt_accept` is its ready. Once a grant is raised it holds its value, whatever the requests do, until the slave port returns `gnt_accept`. The handshake completes on that edge: the winner's bucket is debited, its age is cleared, and the grant drops for one cycle. The next decision is taken in the cycle after that. A master must keep its request and size steady from the moment it is granted until its grant is accepted.

All configuration pins are static. They may change only while reset is asserted.

Top module: `qarb_top`

## Requirements
- R1: Priority is a 4-bit value per master, from 0 to 15. Among the eligible requesters the highest priority wins, and a grant only ever goes to a master that is requesting.
- R2: Every bucket is zero after reset. It gains its master's rate once per clock and saturates at its master's capacity, so the capacity bounds the largest burst.
- R3: When a grant is accepted, the winner's bucket loses the request size. The loss is applied after that cycle's refill, and the result floors at zero.
- R4: A non-opportunistic master is eligible only when its bucket holds at least its request size. Priority does not change this, so a size above capacity is never served through the normal rules.
- R5: A master with its opportunistic bit set skips the token check and its bucket is never debited. It is served only when no non-opportunistic master is eligible.
- R6: Ties in priority go round-robin, starting from the master after the last accepted one. After reset, master 0 is first in line. The pointer moves only when a grant is accepted.
- R7: The grant is registered and has at most one bit set. It is held unchanged until accepted, it is low in the cycle after an acceptance, and a new decision is made one cycle later.
- R8: A master's age counts the clock edges its request has been pending. It clears when the request is withdrawn or accepted, and it saturates instead of wrapping. The request is escalated when its age exceeds the master's threshold.
- R9: An escalated request wins even when its master has no tokens and a higher-priority master is eligible. Between several escalated requests the greatest age wins, and equal ages go to the lower index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | N | Request bit per master |
| req_size | input | N*SIZE_W | Transfer size in bytes per master, master 0 in the low field |
| gnt_onehot | output | N | Registered one-hot grant, acting as valid |
| gnt_accept | input | 1 | Slave port takes the granted transfer, acting as ready |
| cfg_prio | input | N*4 | Priority per master |
| cfg_rate | input | N*TOK_W | Tokens added per clock, per master |
| cfg_cap | input | N*TOK_W | Bucket capacity per master |
| cfg_age_lim | input | N*AGE_W | Escalation threshold in cycles, per master |
| cfg_opport | input | N | Opportunistic flag per master |

## Verification
The bench builds the arbiter with three masters, 10-bit buckets, 8-bit sizes and 8-bit ages. With three masters it can set up three-way priority orders, a full round-robin rotation, and two escalated requests of different ages that compete while a third master holds the grant. With 10-bit buckets, a small capacity can be placed below a request size, so a master can be made permanently starved. A slow refill rate of 1 token per clock makes the cycle at which a drained bucket becomes eligible again exact enough to check.

// File: rtl/qarb_pkg.sv
package qarb_pkg;
  localparam int PRIO_W = 4;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_ESC,
    SRC_TOK,
    SRC_OPP
  } src_e;
endpackage

// File: rtl/qarb_bucket.sv
module qarb_bucket #(
  parameter int TOK_W  = 10,
  parameter int SIZE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TOK_W-1:0]  rate,
  input  logic [TOK_W-1:0]  cap,
  input  logic              debit,
  input  logic [SIZE_W-1:0] size,
  output logic [TOK_W-1:0]  tok
);
  logic [TOK_W:0]   sum;
  logic [TOK_W-1:0] filled;
  logic [TOK_W-1:0] size_x;
  logic [TOK_W-1:0] tok_d;

  assign sum    = {1'b0, tok} + {1'b0, rate};
  assign filled = (sum > {1'b0, cap}) ? cap : sum[TOK_W-1:0];
  assign size_x = TOK_W'(size);

  always_comb begin
    tok_d = filled;
    if (debit) tok_d = (filled >= size_x) ? filled - size_x : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tok <= '0;
    else        tok <= tok_d;
  end
endmodule

// File: rtl/qarb_age.sv
module qarb_age #(
  parameter int AGE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend,
  input  logic             clear,
  output logic [AGE_W-1:0] age
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age <= '0;
    else if (!pend || clear) age <= '0;
    else if (age != '1)      age <= age + 1'b1;
  end
endmodule

// File: rtl/qarb_pick.sv
module qarb_pick
  import qarb_pkg::*;
#(
  parameter int N      = 3,
  parameter int TOK_W  = 10,
  parameter int SIZE_W = 8,
  parameter int AGE_W  = 8,
  parameter int IDX_W  = 2
) (
  input  logic [N-1:0]      valid,
  input  logic [N-1:0]      opp,
  input  logic [SIZE_W-1:0] size [N],
  input  logic [PRIO_W-1:0] prio [N],
  input  logic [TOK_W-1:0]  tok  [N],
  input  logic [AGE_W-1:0]  age  [N],
  input  logic [AGE_W-1:0]  thr  [N],
  input  logic [IDX_W-1:0]  rr,
  output logic [N-1:0]      win
);
  logic [N-1:0]      esc, elig, oppr, pool;
  logic [N-1:0]      esc_win, rr_win;
  logic [AGE_W-1:0]  best_age;
  logic              esc_found, rr_hit;
  logic [PRIO_W-1:0] top_p;
  src_e              src;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      esc[i]  = valid[i] && (age[i] > thr[i]);
      elig[i] = valid[i] && !opp[i] && (tok[i] >= TOK_W'(size[i]));
      oppr[i] = valid[i] && opp[i];
    end
  end

  always_comb begin
    if (|esc)       src = SRC_ESC;
    else if (|elig) src = SRC_TOK;
    else if (|oppr) src = SRC_OPP;
    else            src = SRC_NONE;
  end

  // oldest escalated request, strict compare keeps the lower index on ties
  always_comb begin
    esc_win   = '0;
    best_age  = '0;
    esc_found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (esc[i] && (!esc_found || age[i] > best_age)) begin
        esc_found  = 1'b1;
        best_age   = age[i];
        esc_win    = '0;
        esc_win[i] = 1'b1;
      end
    end
  end

  // highest priority in the pool, round-robin among equals
  always_comb begin
    pool   = (src == SRC_TOK) ? elig : oppr;
    top_p  = '0;
    rr_win = '0;
    rr_hit = 1'b0;
    for (int i = 0; i < N; i++)
      if (pool[i] && prio[i] > top_p) top_p = prio[i];
    for (int k = 1; k <= N; k++) begin
      int j;
      j = (int'(rr) + k) % N;
      if (!rr_hit && pool[j] && prio[j] == top_p) begin
        rr_hit    = 1'b1;
        rr_win[j] = 1'b1;
      end
    end
  end

  always_comb begin
    case (src)
      SRC_ESC:  win = esc_win;
      SRC_NONE: win = '0;
      default:  win = rr_win;
    endcase
  end
endmodule

// File: rtl/qarb_top.sv
module qarb_top
  import qarb_pkg::*;
#(
  parameter int N      = 3,
  parameter int TOK_W  = 10,
  parameter int SIZE_W = 8,
  parameter int AGE_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        req_valid,
  input  logic [N*SIZE_W-1:0] req_size,
  output logic [N-1:0]        gnt_onehot,
  input  logic                gnt_accept,
  input  logic [N*PRIO_W-1:0] cfg_prio,
  input  logic [N*TOK_W-1:0]  cfg_rate,
  input  logic [N*TOK_W-1:0]  cfg_cap,
  input  logic [N*AGE_W-1:0]  cfg_age_lim,
  input  logic [N-1:0]        cfg_opport
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]      gnt_q, take, win;
  logic [IDX_W-1:0]  rr_q, gidx;
  logic [SIZE_W-1:0] size_a [N];
  logic [PRIO_W-1:0] prio_a [N];
  logic [TOK_W-1:0]  tok_a  [N];
  logic [AGE_W-1:0]  age_a  [N];
  logic [AGE_W-1:0]  thr_a  [N];

  assign take = gnt_q & {N{gnt_accept}};

  for (genvar i = 0; i < N; i++) begin : g_mst
    assign size_a[i] = req_size[i*SIZE_W +: SIZE_W];
    assign prio_a[i] = cfg_prio[i*PRIO_W +: PRIO_W];
    assign thr_a[i]  = cfg_age_lim[i*AGE_W +: AGE_W];

    qarb_bucket #(.TOK_W(TOK_W), .SIZE_W(SIZE_W)) u_bkt (
      .clk   (clk),
      .rst_n (rst_n),
      .rate  (cfg_rate[i*TOK_W +: TOK_W]),
      .cap   (cfg_cap[i*TOK_W +: TOK_W]),
      .debit (take[i] & ~cfg_opport[i]),
      .size  (size_a[i]),
      .tok   (tok_a[i])
    );

    qarb_age #(.AGE_W(AGE_W)) u_age (
      .clk   (clk),
      .rst_n (rst_n),
      .pend  (req_valid[i]),
      .clear (take[i]),
      .age   (age_a[i])
    );
  end

  qarb_pick #(
    .N(N), .TOK_W(TOK_W), .SIZE_W(SIZE_W), .AGE_W(AGE_W), .IDX_W(IDX_W)
  ) u_pick (
    .valid (req_valid),
    .opp   (cfg_opport),
    .size  (size_a),
    .prio  (prio_a),
    .tok   (tok_a),
    .age   (age_a),
    .thr   (thr_a),
    .rr    (rr_q),
    .win   (win)
  );

  always_comb begin
    gidx = '0;
    for (int i = 0; i < N; i++)
      if (gnt_q[i]) gidx = IDX_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q <= '0;
      rr_q  <= IDX_W'(N - 1);
    end else if (gnt_q != '0) begin
      if (gnt_accept) begin
        gnt_q <= '0;
        rr_q  <= gidx;
      end
    end else begin
      gnt_q <= win;
    end
  end

  assign gnt_onehot = gnt_q;
endmodule

// File: rtl/qarb_chk.sv
module qarb_chk #(
  parameter int N = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req_valid,
  input logic [N-1:0] gnt_onehot,
  input logic         gnt_accept
);
  assert_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_onehot));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_onehot != '0 && !gnt_accept) |=> gnt_onehot == $past(gnt_onehot));

  assert_gap_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_onehot != '0 && gnt_accept) |=> gnt_onehot == '0);

  assert_gnt_to_requester_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_onehot != '0) |-> (gnt_onehot & req_valid) != '0);

  assert_idle_stays_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_onehot == '0 && req_valid == '0) |=> gnt_onehot == '0);
endmodule

bind qarb_top qarb_chk #(.N(N)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .gnt_onehot (gnt_onehot),
  .gnt_accept (gnt_accept)
);

// File: tb/tb_qarb_top.sv
module tb_qarb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3, TOK_W = 10, SIZE_W = 8, AGE_W = 8;

  logic clk = 1'b0, rst_n = 1'b0, gnt_accept = 1'b0;
  logic [N-1:0] req_valid = '0, cfg_opport = '0, gnt_onehot;
  logic [3:0]        b_prio [N];
  logic [TOK_W-1:0]  b_rate [N], b_cap [N];
  logic [SIZE_W-1:0] b_size [N];
  logic [AGE_W-1:0]  b_thr  [N];
  logic [N*4-1:0]      cfg_prio;
  logic [N*TOK_W-1:0]  cfg_rate, cfg_cap;
  logic [N*SIZE_W-1:0] req_size;
  logic [N*AGE_W-1:0]  cfg_age_lim;
  int checks = 0, errors = 0;

  assign cfg_prio    = {b_prio[2], b_prio[1], b_prio[0]};
  assign cfg_rate    = {b_rate[2], b_rate[1], b_rate[0]};
  assign cfg_cap     = {b_cap[2],  b_cap[1],  b_cap[0]};
  assign req_size    = {b_size[2], b_size[1], b_size[0]};
  assign cfg_age_lim = {b_thr[2],  b_thr[1],  b_thr[0]};

  always #(CLK_PERIOD/2) clk = ~clk;

  qarb_top #(.N(N), .TOK_W(TOK_W), .SIZE_W(SIZE_W), .AGE_W(AGE_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
    .gnt_onehot(gnt_onehot), .gnt_accept(gnt_accept), .cfg_prio(cfg_prio),
    .cfg_rate(cfg_rate), .cfg_cap(cfg_cap), .cfg_age_lim(cfg_age_lim),
    .cfg_opport(cfg_opport)
  );

  typedef struct packed {
    logic [3:0] p0, p1, p2;
    logic [2:0] opp, vld;
    logic [7:0] size2;
    logic [9:0] cap2;
    logic [2:0] exp;
  } vec_t;
  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{4'd5,  4'd12, 4'd15, 3'b000, 3'b111, 8'd8,  10'd64, 3'b100}, // R1
    '{4'd5,  4'd12, 4'd15, 3'b000, 3'b111, 8'd32, 10'd16, 3'b010}, // R4
    '{4'd7,  4'd7,  4'd7,  3'b000, 3'b111, 8'd8,  10'd64, 3'b001}, // R6
    '{4'd15, 4'd1,  4'd0,  3'b001, 3'b011, 8'd8,  10'd64, 3'b010}, // R5
    '{4'd15, 4'd1,  4'd0,  3'b001, 3'b001, 8'd8,  10'd64, 3'b001}, // R5
    '{4'd3,  4'd3,  4'd15, 3'b100, 3'b111, 8'd8,  10'd64, 3'b001}, // R5
    '{4'd3,  4'd9,  4'd15, 3'b000, 3'b000, 8'd8,  10'd64, 3'b000}  // R1
  };

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [N-1:0] exp, input string tag);
    checks++;
    if (gnt_onehot !== exp) begin
      errors++;
      $display("FAIL %s: grant actual %b expected %b", tag, gnt_onehot, exp);
    end
  endtask

  task automatic defaults;
    for (int i = 0; i < N; i++) begin
      b_prio[i] = 4'd0; b_rate[i] = 10'd4; b_cap[i] = 10'd64;
      b_size[i] = 8'd8; b_thr[i] = 8'd200;
    end
    cfg_opport = '0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0; req_valid = '0; gnt_accept = 1'b0;
    tick(2);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R7: actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    defaults();
    tick(1);
    chk('0, "R7 grant low in reset");
    do_reset();

    // R2: buckets start empty, refill 4 per clock, size 8 needs two edges
    req_valid = 3'b001;
    tick(1); chk('0, "R2 empty after reset");
    tick(1); chk('0, "R2 still short");
    tick(1); chk(3'b001, "R2 refilled");

    for (int v = 0; v < NV; v++) begin
      defaults();
      b_prio[0] = VECS[v].p0; b_prio[1] = VECS[v].p1; b_prio[2] = VECS[v].p2;
      b_size[2] = VECS[v].size2; b_cap[2] = VECS[v].cap2;
      cfg_opport = VECS[v].opp;
      do_reset();
      tick(30);
      req_valid = VECS[v].vld;
      tick(1);
      chk(VECS[v].exp, $sformatf("vector %0d (R1 R4 R5 R6)", v));
    end

    // R3: cap 12, rate 1, size 8 -> 4 left, eligible again after 4 refills
    defaults(); b_rate[0] = 10'd1; b_cap[0] = 10'd12;
    do_reset(); tick(30);
    req_valid = 3'b001;
    tick(1); chk(3'b001, "R3 first grant");
    gnt_accept = 1'b1;
    tick(1); gnt_accept = 1'b0;
    chk('0, "R7 gap after accept");
    tick(4); chk('0, "R3 drained bucket");
    tick(1); chk(3'b001, "R3 refilled to size");

    // R6: round-robin rotates only on acceptance
    defaults(); for (int i = 0; i < N; i++) b_prio[i] = 4'd7;
    do_reset(); tick(30);
    req_valid = 3'b111;
    tick(1); chk(3'b001, "R6 first m0");
    for (int r = 1; r <= 3; r++) begin
      gnt_accept = 1'b1; tick(1); gnt_accept = 1'b0;
      tick(1);
      chk(3'b001 << (r % 3), $sformatf("R6 rotation %0d", r));
    end

    // R9: escalated starved low-priority master beats eligible priority 15
    defaults(); b_size[0] = 8'd32; b_cap[0] = 10'd16; b_thr[0] = 8'd3;
    b_prio[1] = 4'd15;
    do_reset(); tick(30);
    req_valid = 3'b011;
    tick(1); chk(3'b010, "R1 m1 wins first");
    tick(2); chk(3'b010, "R7 held without accept");
    tick(2); gnt_accept = 1'b1;
    tick(1); gnt_accept = 1'b0;
    tick(1); chk(3'b001, "R9 escalation overrides");

    // R9: older escalated request wins over lower index
    defaults();
    for (int i = 0; i < 2; i++) begin b_size[i] = 8'd32; b_cap[i] = 10'd16; b_thr[i] = 8'd2; end
    b_prio[2] = 4'd15;
    do_reset(); tick(30);
    req_valid = 3'b110;
    tick(1); chk(3'b100, "R9 m2 holds port");
    tick(1); req_valid = 3'b111;
    tick(8); gnt_accept = 1'b1;
    tick(1); gnt_accept = 1'b0;
    tick(1); chk(3'b010, "R9 older wins");

    // R9: equal ages go to lower index
    do_reset(); tick(30);
    req_valid = 3'b111;
    tick(1); chk(3'b100, "R9 m2 holds port again");
    tick(2); gnt_accept = 1'b1;
    tick(1); gnt_accept = 1'b0;
    tick(1); chk(3'b001, "R9 tie lower index");

    // R8: withdrawal clears age, escalation restarts from zero
    defaults(); b_size[0] = 8'd32; b_cap[0] = 10'd16; b_thr[0] = 8'd3;
    do_reset(); tick(30);
    req_valid = 3'b001;
    tick(2); req_valid = 3'b000;
    tick(1); req_valid = 3'b001;
    tick(4); chk('0, "R8 age restarted");
    tick(1); chk(3'b001, "R8 escalates after threshold");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule